// File: doc/BRIEF.md
# Successive-Approximation Controller for a Discrete DAC and Comparator

This block converts a voltage with a separate DAC and a separate comparator, which together act as an N-bit converter. A pulse on the start input wakes the external parts by releasing their shutdown line. After a programmable wake-up delay the block sets the bits one at a time, starting at the most significant. For each bit it writes a trial code to the DAC over a parallel bus with a one-cycle strobe. It then waits a programmable settle time and captures the comparator output in a flip-flop at one fixed edge. The bit stays set when the comparator reports that the input is above the DAC level.

An optional mode writes code zero to the DAC after every decided bit, except the last, and waits its own settle time. This makes each threshold approach from below and cancels comparator hysteresis. The DAC can also serve another function, such as holding a display bias, while the block is idle. Idle writes pass through to the DAC and are remembered. After the last bit the block writes the remembered code back, registers the result, pulses done and shuts the external parts down again.

Top module: `sar_dac_ctrl`

## Requirements
- R1: Each trial code equals the bits already decided plus the weight of the bit under test. Weights are tried from bit NBITS-1 down to bit 0.
- R2: A tested bit is kept when `cmp_i` is 1 at its sampling edge and cleared when it is 0. With a comparator that reports input >= code, the result equals the input code.
- R3: After a trial write, no DAC write occurs for `settle_cnt_i` cycles. The comparator is sampled at the edge `settle_cnt_i`+1 cycles after the trial write, and the next write appears at that same edge.
- R4: With `rtz_en_i` high at start, code 0 is written one sample period after every trial except the last. The next trial follows `rtz_cnt_i`+1 cycles later. With `rtz_en_i` low, no zero writes occur.
- R5: `shdn_o` falls at the edge that accepts start and stays low through the conversion. The first trial write follows `wake_cnt_i`+1 cycles after that edge.
- R6: While idle, `busy_o` is 0 and `shdn_o` is 1, including directly after reset.
- R7: The final write of a conversion restores the last code written through the idle pass-through path. It occurs in the same cycle as `done_o`.
- R8: `done_o` is high for exactly one cycle, and `result_o` holds the conversion value afterwards.
- R9: A start pulse while busy is ignored. The write sequence and its timing are unchanged.
- R10: While idle, `host_wr_i` writes `host_code_i` to the DAC, with `dac_wr_o` high in the next cycle. While busy, host writes are ignored and do not change the code that is later restored.
- R11: The resolution comes from the NBITS parameter. Both 8-bit and 12-bit builds convert correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-conversion pulse |
| rtz_en_i | input | 1 | Return-to-zero mode for the coming conversion |
| wake_cnt_i | input | CNT_W | Wake-up delay after shutdown release |
| settle_cnt_i | input | CNT_W | Settle cycles after each trial write |
| rtz_cnt_i | input | CNT_W | Settle cycles after each zero write |
| host_wr_i | input | 1 | Idle-time DAC write from the sharing function |
| host_code_i | input | NBITS | Code for the idle-time write |
| cmp_i | input | 1 | Comparator output, 1 when input is above the DAC level |
| dac_code_o | output | NBITS | DAC code bus |
| dac_wr_o | output | 1 | DAC write strobe, one cycle per write |
| shdn_o | output | 1 | Shutdown for the external DAC and comparator |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | NBITS | Registered conversion result |

## Verification
The hardest case to reach from the ports is a foreign write arriving mid-conversion. A start pulse and a host write both land while the block waits between trials. The only visible evidence that they were dropped is the later restore code and the unchanged write timing. The bench injects both a few cycles into a conversion. Its scoreboard predicts every DAC write, with its code and its cycle gap, so a stray restart or an overwritten saved code appears as a mismatch. Return-to-zero runs with different settle and zero-settle counts separate the two delays.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAKE   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RTZ    = 2'd3
    } sar_state_t;
endpackage

// File: rtl/sar_timer.sv
// Down-counter for wake, settle and zero-settle waits.
// A load sets the count. While run is high the count decreases by one
// per cycle until it reaches zero, which zero_o reports.
// Assumes: load has priority over run.
module sar_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load, or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load_i)                cnt_q <= val_i;
        else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_engine.sv
// Holds the decided bits and a one-hot weight for the bit under test.
// init clears the decided bits and points at the MSB. sample keeps or
// drops the current bit from cmp_i and moves to the next lower weight.
// Assumes: sample is not raised after the last bit until the next init.
module sar_bit_engine #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             sample_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] kept_o,
    output logic [NBITS-1:0] next_trial_o,
    output logic             last_o
);
    localparam logic [NBITS-1:0] MSB_W = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] acc_q;
    logic [NBITS-1:0] wgt_q;

    // Decided bits with the current bit kept or dropped by the comparator.
    assign kept_o       = cmp_i ? (acc_q | wgt_q) : acc_q;
    assign trial_o      = acc_q | wgt_q;
    assign next_trial_o = kept_o | (wgt_q >> 1);
    assign last_o       = wgt_q[0];

    // Decided-bit register and weight shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            wgt_q <= '0;
        end else if (init_i) begin
            acc_q <= '0;
            wgt_q <= MSB_W;
        end else if (sample_i) begin
            acc_q <= kept_o;
            wgt_q <= wgt_q >> 1;
        end
    end

    // R1
    weight_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wgt_q));
endmodule

// File: rtl/sar_dac_ctrl.sv
// Successive-approximation controller for an external DAC and comparator.
// It sequences wake-up, trial writes, settle waits, comparator sampling,
// optional return-to-zero writes and the restore of a shared DAC code.
// Assumes: cmp_i is synchronous to clk at its sampling edge, and the count
// inputs are held steady during a conversion.
module sar_dac_ctrl #(
    parameter int NBITS = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rtz_en_i,
    input  logic [CNT_W-1:0] wake_cnt_i,
    input  logic [CNT_W-1:0] settle_cnt_i,
    input  logic [CNT_W-1:0] rtz_cnt_i,
    input  logic             host_wr_i,
    input  logic [NBITS-1:0] host_code_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] dac_code_o,
    output logic             dac_wr_o,
    output logic             shdn_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);
    import sar_pkg::*;

    sar_state_t       st_q;
    logic [NBITS-1:0] dac_q, saved_q, result_q;
    logic             wr_q, shdn_q, done_q, rtz_q;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             idle, go, sample;
    logic [NBITS-1:0] trial, kept, next_trial;
    logic             last;

    assign idle   = (st_q == ST_IDLE);
    assign go     = idle && start_i;
    assign sample = (st_q == ST_SETTLE) && tmr_zero;

    // Choose which wait to load next.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = settle_cnt_i;
        if (go) begin
            tmr_load = 1'b1;
            tmr_val  = wake_cnt_i;
        end else if (!idle && tmr_zero) begin
            tmr_load = !(sample && last);
            tmr_val  = (sample && rtz_q) ? rtz_cnt_i : settle_cnt_i;
        end
    end

    sar_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .run_i  (!idle),
        .zero_o (tmr_zero)
    );

    sar_bit_engine #(.NBITS(NBITS)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (go),
        .sample_i     (sample),
        .cmp_i        (cmp_i),
        .trial_o      (trial),
        .kept_o       (kept),
        .next_trial_o (next_trial),
        .last_o       (last)
    );

    // Sequencer: state, DAC bus, shutdown, done and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            dac_q    <= '0;
            saved_q  <= '0;
            result_q <= '0;
            wr_q     <= 1'b0;
            shdn_q   <= 1'b1;
            done_q   <= 1'b0;
            rtz_q    <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_WAKE;
                        shdn_q <= 1'b0;
                        rtz_q  <= rtz_en_i;
                    end else if (host_wr_i) begin
                        dac_q   <= host_code_i;
                        saved_q <= host_code_i;
                        wr_q    <= 1'b1;
                    end
                end
                ST_WAKE, ST_RTZ: begin
                    if (tmr_zero) begin
                        dac_q <= trial;
                        wr_q  <= 1'b1;
                        st_q  <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        wr_q <= 1'b1;
                        if (last) begin
                            dac_q    <= saved_q;
                            result_q <= kept;
                            done_q   <= 1'b1;
                            shdn_q   <= 1'b1;
                            st_q     <= ST_IDLE;
                        end else if (rtz_q) begin
                            dac_q <= '0;
                            st_q  <= ST_RTZ;
                        end else begin
                            dac_q <= next_trial;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign dac_code_o = dac_q;
    assign dac_wr_o   = wr_q;
    assign shdn_o     = shdn_q;
    assign busy_o     = !idle;
    assign done_o     = done_q;
    assign result_o   = result_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    shdn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> shdn_o);

    // R7
    restore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dac_wr_o && dac_code_o == saved_q));

    // R10
    saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && host_wr_i) |=> $stable(saved_q));

    // R3
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE && !tmr_zero) |=> !dac_wr_o);

    // R4
    rtz_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RTZ && !tmr_zero) |=> (dac_code_o == '0 && !dac_wr_o));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE && start_i) |=> (st_q != ST_WAKE));
endmodule

// File: tb/test_sar_dac_ctrl.sv
module test_sar_dac_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       start_i = 1'b0, rtz_en_i = 1'b0, host_wr_i = 1'b0;
    logic [7:0] wake_cnt_i = 8'd0, settle_cnt_i = 8'd0, rtz_cnt_i = 8'd0;
    logic [7:0] host_code_i = 8'd0;
    logic [7:0] vin = 8'd0;
    logic       cmp_i;
    logic [7:0] dac_code_o, result_o;
    logic       dac_wr_o, shdn_o, busy_o, done_o;

    // Comparator model: input sits half a code above vin.
    assign cmp_i = (int'(vin) * 2 + 1) > (int'(dac_code_o) * 2);

    sar_dac_ctrl #(.NBITS(8), .CNT_W(8)) i_sar_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rtz_en_i(rtz_en_i),
        .wake_cnt_i(wake_cnt_i), .settle_cnt_i(settle_cnt_i),
        .rtz_cnt_i(rtz_cnt_i), .host_wr_i(host_wr_i),
        .host_code_i(host_code_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
        .dac_wr_o(dac_wr_o), .shdn_o(shdn_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o));

    // Second build at 12 bits.
    logic        start12 = 1'b0;
    logic [11:0] vin12 = 12'd0;
    logic [11:0] dac12, res12;
    logic        cmp12, wr12, shdn12, busy12, done12;
    assign cmp12 = (int'(vin12) * 2 + 1) > (int'(dac12) * 2);

    sar_dac_ctrl #(.NBITS(12), .CNT_W(6)) i_sar12 (
        .clk(clk), .rst_n(rst_n), .start_i(start12), .rtz_en_i(1'b1),
        .wake_cnt_i(6'd2), .settle_cnt_i(6'd1), .rtz_cnt_i(6'd0),
        .host_wr_i(1'b0), .host_code_i(12'd0), .cmp_i(cmp12),
        .dac_code_o(dac12), .dac_wr_o(wr12), .shdn_o(shdn12),
        .busy_o(busy12), .done_o(done12), .result_o(res12));

    typedef struct {
        logic [7:0] code;
        int         gap;
        bit         fin;
        string      req;
    } wr_item_t;

    wr_item_t   exp_q[$];
    int         checks = 0, fails = 0;
    int         cyc = 0, last_edge = 0;
    logic [7:0] saved_m = 8'd0;
    logic [7:0] exp_res = 8'd0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: pop expected writes and compare code, gap and end flags.
    always @(negedge clk) begin
        if (rst_n && dac_wr_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected write", int'(dac_code_o), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(dac_code_o == it.code, it.req, int'(dac_code_o), int'(it.code));
                if (it.gap >= 0)
                    chk(cyc - last_edge == it.gap, "R3/R4/R5 write gap", cyc - last_edge, it.gap);
                if (it.fin) begin
                    chk(done_o == 1'b1, "R7 done with restore", int'(done_o), 1);
                    chk(result_o == exp_res, "R2 result", int'(result_o), int'(exp_res));
                    chk(shdn_o == 1'b1 && busy_o == 1'b0, "R6 idle after done", int'(shdn_o), 1);
                end else if (it.gap >= 0) begin
                    chk(shdn_o == 1'b0 && done_o == 1'b0, "R5 awake mid-conversion", int'(shdn_o), 0);
                end
            end
            last_edge = cyc;
        end
    end

    // Driver: predict the full write sequence, then start the conversion.
    task automatic run_conv(input logic [7:0] v, input bit rtz, input int wk,
                            input int st, input int rz, input bit disturb);
        logic [7:0] acc;
        int         g;
        acc = 8'd0;
        g   = wk + 1;
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] t;
            t = acc | (8'd1 << i);
            exp_q.push_back('{t, g, 1'b0, "R1 trial code"});
            if (v >= t) acc = t;
            g = st + 1;
            if (rtz && i > 0) begin
                exp_q.push_back('{8'd0, g, 1'b0, "R4 zero write"});
                g = rz + 1;
            end
        end
        exp_q.push_back('{saved_m, g, 1'b1, "R7 restore code"});
        exp_res = v;
        @(negedge clk);
        vin = v; rtz_en_i = rtz;
        wake_cnt_i = 8'(wk); settle_cnt_i = 8'(st); rtz_cnt_i = 8'(rz);
        start_i = 1'b1;
        last_edge = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; host_wr_i = 1'b1; host_code_i = 8'h33;
            @(negedge clk);
            start_i = 1'b0; host_wr_i = 1'b0;
        end
        for (int k = 0; k < 5000 && exp_q.size() != 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, "R2 conversion completes", exp_q.size(), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
        chk(result_o == v, "R8 result holds", int'(result_o), int'(v));
    endtask

    task automatic host_write(input logic [7:0] c);
        exp_q.push_back('{c, -1, 1'b0, "R10 host pass-through"});
        @(negedge clk);
        host_wr_i = 1'b1; host_code_i = c;
        @(negedge clk);
        host_wr_i = 1'b0;
        saved_m = c;
        @(negedge clk);
        chk(exp_q.size() == 0, "R10 host write seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(shdn_o == 1'b1, "R6 reset shdn", int'(shdn_o), 1);
        chk(busy_o == 1'b0 && done_o == 1'b0 && dac_wr_o == 1'b0,
            "R6 reset idle", int'(busy_o), 0);

        host_write(8'h5A);
        run_conv(8'hA5, 1'b0, 0, 0, 0, 1'b0);
        run_conv(8'h00, 1'b0, 5, 3, 0, 1'b0);
        run_conv(8'hFF, 1'b1, 2, 1, 4, 1'b0);
        run_conv(8'h80, 1'b1, 0, 2, 0, 1'b0);
        // R9 R10 start and host write during busy are ignored
        run_conv(8'h7F, 1'b1, 1, 4, 2, 1'b1);
        host_write(8'hC3);
        run_conv(8'h3C, 1'b0, 3, 2, 7, 1'b1);

        // R11 12-bit build
        @(negedge clk);
        vin12 = 12'hABC; start12 = 1'b1;
        @(negedge clk);
        start12 = 1'b0;
        chk(shdn12 == 1'b0 && busy12 == 1'b1, "R11 12-bit awake", int'(shdn12), 0);
        for (int k = 0; k < 2000 && !done12; k++) @(negedge clk);
        chk(done12 == 1'b1, "R11 12-bit done", int'(done12), 1);
        chk(res12 == 12'hABC, "R11 12-bit result", int'(res12), 'hABC);
        chk(wr12 == 1'b1 && dac12 == 12'd0, "R11 12-bit restore", int'(dac12), 0);

        summary();
        $finish;
    end
endmodule